// File: doc/BRIEF.md
# Receive Descriptor Sequencer

This block runs the receive side of a descriptor-driven Ethernet controller. Software issues commands to move the receive unit between idle, ready and suspended, and to set the base and the current offset of a chain of receive descriptors in memory. Each incoming frame is judged against length and address filters. A frame that passes while the unit is ready is bound to the current descriptor. The block reads the descriptor's command and link words, writes back a status word and a byte count, and then moves to the linked descriptor. If that descriptor's control bits ask for it, the unit then suspends.

Frame payload movement, CRC checking and the line interface belong to neighbouring blocks. This block supplies the decisions, the descriptor bookkeeping, one-cycle event pulses for the interrupt logic and one-cycle increment strobes for the statistics counters. Descriptor memory sits behind a request/response port. The port handles one word per access. The request stays high until a response strobe arrives.

Top module: `rx_desc_seq`

## Requirements
- R1: After reset the unit state reads idle (0), `busy` and `mem_req` are low, and no event or statistic strobe is raised.
- R2: Commands are accepted on `cmd_valid` while not busy. Start (1) sets the state to ready (4) and loads the descriptor offset from `cmd_ptr`. Resume (2) sets ready. Load-base (6) loads the descriptor base from `cmd_ptr`. Every descriptor lives at base plus offset.
- R3: Abort (4) forces the state to idle. It raises one `ev_rnr` pulse only if the unit was ready.
- R4: The codes 0, 3, 5 and 7 leave the state unchanged and raise no event.
- R5: A frame that passes the filters while the state is not ready raises `ev_rnr` and `st_rsrc` together and makes no memory access.
- R6: With `cfg_short_cnt` set, a frame shorter than 64 bytes raises `st_short`. It is still filtered and stored normally.
- R7: A frame longer than MAX_FRAME+4 bytes (1518 by default) is dropped with no access and no event, unless `cfg_long_ok` is set.
- R8: A frame whose 48-bit destination equals `ind_addr` is accepted. Its written status is 0xA000 (bit 15 complete, bit 13 OK).
- R9: A destination with bit 40 set is multicast. It is accepted when `hash_tbl` has a 1 at the index formed by XORing the eight 6-bit slices of the destination. Its status then also carries 0x0002. A multicast frame that misses the table is dropped when not promiscuous.
- R10: With `cfg_promisc` set, every frame within length limits is accepted. The status of a non-matching unicast frame carries 0x0004. The status of a multicast frame that misses the table carries 0x0006.
- R11: A stored frame produces four accesses in a fixed order. First a read at +0, whose bits 31:16 are the descriptor command. Then a read at +4, which gives the link. Then a write at +0 of {command, status}. Last, a write at +12 of the zero-extended length. After these, `ev_frame` and `st_good` pulse once, and the offset takes the link.
- R12: On completion a ready unit goes to suspended (1) if command bit 15 (end of list) or bit 14 (suspend) is set. Otherwise it stays ready.
- R13: While `busy` is high, commands and frames are ignored.
- R14: When a command and a frame arrive in the same cycle, the frame is judged against the state held before the command. The completion of such a frame suspends the unit only if the unit is still ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Receive command code |
| cmd_ptr | input | ADDR_W | Pointer operand for start and load-base |
| frm_valid | input | 1 | Frame arrival strobe |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_dst | input | 48 | Destination address, first octet in bits 47:40 |
| ind_addr | input | 48 | Station individual address |
| hash_tbl | input | 2**HASH_BITS | Multicast hash table |
| cfg_short_cnt | input | 1 | Count short frames |
| cfg_long_ok | input | 1 | Accept over-length frames |
| cfg_promisc | input | 1 | Promiscuous acceptance |
| mem_req | output | 1 | Descriptor access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Access byte address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Access response strobe |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Descriptor sequence in progress |
| ru_state | output | 4 | Unit state: 0 idle, 1 suspended, 4 ready |
| ev_frame | output | 1 | Frame-received event pulse |
| ev_rnr | output | 1 | Receiver-not-ready event pulse |
| st_good | output | 1 | Good-frame statistic strobe |
| st_short | output | 1 | Short-frame statistic strobe |
| st_rsrc | output | 1 | Resource-error statistic strobe |

## Verification
A command and a frame arrival can fall in the same cycle. The hardest case is an abort meeting a frame while the unit is ready. The bench raises `cmd_valid` and `frm_valid` on the same clock edge for this. It then judges the result from three observations. The frame must still be stored at the pre-abort descriptor. Exactly one `ev_rnr` must come from the abort. The state must read idle both during and after the descriptor sequence, even though that descriptor carries the suspend bit. A follow-up resume and frame confirm that the offset still moved to the link.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

   typedef enum logic [3:0] {
      RU_IDLE  = 4'd0,
      RU_SUSP  = 4'd1,
      RU_NORES = 4'd2,
      RU_READY = 4'd4
   } ru_state_e;

   localparam logic [2:0] C_NOP    = 3'd0;
   localparam logic [2:0] C_START  = 3'd1;
   localparam logic [2:0] C_RESUME = 3'd2;
   localparam logic [2:0] C_ABORT  = 3'd4;
   localparam logic [2:0] C_LOADB  = 3'd6;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RD0,
      PH_RD1,
      PH_WR0,
      PH_WR3
   } phase_e;

   localparam logic [15:0] ST_COMPLETE = 16'h8000;
   localparam logic [15:0] ST_OK       = 16'h2000;
   localparam logic [15:0] ST_MCAST    = 16'h0002;
   localparam logic [15:0] ST_PROMISC  = 16'h0004;

endpackage

// File: rtl/rxs_filter.sv
module rxs_filter
   import rxs_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int MAX_FRAME = 1514,
   parameter int MIN_FRAME = 64,
   parameter int HASH_BITS = 6
) (
   input  logic [LEN_W-1:0]          len,
   input  logic [47:0]               dst,
   input  logic [47:0]               ind_addr,
   input  logic [(1<<HASH_BITS)-1:0] hash_tbl,
   input  logic                      cfg_promisc,
   input  logic                      cfg_long_ok,
   output logic                      pass,
   output logic                      is_short,
   output logic [15:0]               status
);
   localparam int NSL = 48 / HASH_BITS;
   localparam logic [LEN_W-1:0] LONG_LIM = LEN_W'(MAX_FRAME + 4);
   localparam logic [LEN_W-1:0] SHORT_LIM = LEN_W'(MIN_FRAME);

   // XOR fold of the destination into a hash index
   logic [HASH_BITS-1:0] fold [0:NSL];
   assign fold[0] = '0;
   for (genvar g = 0; g < NSL; g++) begin : g_fold
      assign fold[g+1] = fold[g] ^ dst[g*HASH_BITS +: HASH_BITS];
   end

   logic too_long, own, mcast, hit;
   assign too_long = (len > LONG_LIM) && !cfg_long_ok;
   assign is_short = (len < SHORT_LIM);
   assign own      = (dst == ind_addr);
   assign mcast    = dst[40];
   assign hit      = hash_tbl[fold[NSL]];

   always_comb begin
      pass   = 1'b0;
      status = '0;
      if (too_long) begin
         pass = 1'b0;
      end else if (own) begin
         pass = 1'b1;
      end else if (mcast) begin
         status = ST_MCAST;
         if (hit) begin
            pass = 1'b1;
         end else if (cfg_promisc) begin
            pass   = 1'b1;
            status = ST_MCAST | ST_PROMISC;
         end
      end else if (cfg_promisc) begin
         pass   = 1'b1;
         status = ST_PROMISC;
      end
   end

endmodule

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
   import rxs_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_code,
   input  logic [ADDR_W-1:0] cmd_ptr,
   input  logic              busy,
   input  logic              done,
   input  logic [ADDR_W-1:0] link,
   input  logic              end_flag,
   output ru_state_e         state,
   output logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] offset,
   output logic              abort_rnr
);
   logic take;
   assign take      = cmd_valid && !busy;
   assign abort_rnr = take && (cmd_code == C_ABORT) && (state == RU_READY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= RU_IDLE;
         base   <= '0;
         offset <= '0;
      end else if (take) begin
         case (cmd_code)
            C_START: begin
               state  <= RU_READY;
               offset <= cmd_ptr;
            end
            C_RESUME: state <= RU_READY;
            C_ABORT:  state <= RU_IDLE;
            C_LOADB:  base  <= cmd_ptr;
            default: ;
         endcase
      end else if (done) begin
         offset <= link;
         if (state == RU_READY && end_flag)
            state <= RU_SUSP;
      end
   end

   a_r2_start_ready: assert property (@(posedge clk) disable iff (!rst_n)
      take && cmd_code == C_START |=> state == RU_READY && offset == $past(cmd_ptr));
   a_r3_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      take && cmd_code == C_ABORT |=> state == RU_IDLE);
   a_r4_unknown_hold: assert property (@(posedge clk) disable iff (!rst_n)
      take && (cmd_code == 3'd0 || cmd_code == 3'd3 || cmd_code == 3'd5 || cmd_code == 3'd7)
      |=> $stable(state));
   a_r13_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> $stable(state) && $stable(base) && $stable(offset));
   a_r12_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      done && end_flag && state == RU_READY |=> state == RU_SUSP);

endmodule

// File: rtl/rxs_walker.sv
module rxs_walker
   import rxs_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] go_addr,
   input  logic [LEN_W-1:0]  go_len,
   input  logic [15:0]       go_status,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] link,
   output logic              end_flag
);
   phase_e            phase;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic [15:0]       stat_q;
   logic [15:0]       cmdw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         addr_q <= '0;
         len_q  <= '0;
         stat_q <= '0;
         cmdw_q <= '0;
         link   <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (go) begin
               phase  <= PH_RD0;
               addr_q <= go_addr;
               len_q  <= go_len;
               stat_q <= go_status;
            end
            PH_RD0: if (mem_rvalid) begin
               cmdw_q <= mem_rdata[31:16];
               phase  <= PH_RD1;
            end
            PH_RD1: if (mem_rvalid) begin
               link  <= mem_rdata[ADDR_W-1:0];
               phase <= PH_WR0;
            end
            PH_WR0: if (mem_rvalid) phase <= PH_WR3;
            PH_WR3: if (mem_rvalid) phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy     = (phase != PH_IDLE);
   assign mem_req  = busy;
   assign mem_we   = (phase == PH_WR0) || (phase == PH_WR3);
   assign done     = (phase == PH_WR3) && mem_rvalid;
   assign end_flag = cmdw_q[15] | cmdw_q[14];

   always_comb begin
      case (phase)
         PH_RD1:  mem_addr = addr_q + ADDR_W'(4);
         PH_WR3:  mem_addr = addr_q + ADDR_W'(12);
         default: mem_addr = addr_q;
      endcase
      if (phase == PH_WR3) mem_wdata = 32'(len_q);
      else                 mem_wdata = {cmdw_q, stat_q | ST_COMPLETE | ST_OK};
   end

   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr) && $stable(mem_we));
   a_r11_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

endmodule

// File: rtl/rx_desc_seq.sv
module rx_desc_seq
   import rxs_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int MAX_FRAME = 1514,
   parameter int MIN_FRAME = 64,
   parameter int HASH_BITS = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cmd_valid,
   input  logic [2:0]                cmd_code,
   input  logic [ADDR_W-1:0]         cmd_ptr,
   input  logic                      frm_valid,
   input  logic [LEN_W-1:0]          frm_len,
   input  logic [47:0]               frm_dst,
   input  logic [47:0]               ind_addr,
   input  logic [(1<<HASH_BITS)-1:0] hash_tbl,
   input  logic                      cfg_short_cnt,
   input  logic                      cfg_long_ok,
   input  logic                      cfg_promisc,
   output logic                      mem_req,
   output logic                      mem_we,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic [31:0]               mem_wdata,
   input  logic                      mem_rvalid,
   input  logic [31:0]               mem_rdata,
   output logic                      busy,
   output logic [3:0]                ru_state,
   output logic                      ev_frame,
   output logic                      ev_rnr,
   output logic                      st_good,
   output logic                      st_short,
   output logic                      st_rsrc
);
   localparam logic [LEN_W-1:0] LONG_LIM = LEN_W'(MAX_FRAME + 4);

   if (LEN_W > 16) begin : g_bad_len
      $error("LEN_W must fit the 16-bit count field");
   end
   if (ADDR_W > 32 || ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must lie between 8 and 32");
   end
   if (48 % HASH_BITS != 0) begin : g_bad_hash
      $error("HASH_BITS must divide 48");
   end

   ru_state_e         state;
   logic [ADDR_W-1:0] base, offset, link;
   logic              pass, is_short, done, end_flag, abort_rnr;
   logic [15:0]       fstat;
   logic              take_f, go, res_err;

   rxs_filter #(
      .LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME), .MIN_FRAME(MIN_FRAME), .HASH_BITS(HASH_BITS)
   ) filt_i (
      .len(frm_len), .dst(frm_dst), .ind_addr(ind_addr), .hash_tbl(hash_tbl),
      .cfg_promisc(cfg_promisc), .cfg_long_ok(cfg_long_ok),
      .pass(pass), .is_short(is_short), .status(fstat)
   );

   rxs_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_ptr(cmd_ptr), .busy(busy), .done(done), .link(link), .end_flag(end_flag),
      .state(state), .base(base), .offset(offset), .abort_rnr(abort_rnr)
   );

   assign take_f  = frm_valid && !busy;
   assign go      = take_f && pass && (state == RU_READY);
   assign res_err = take_f && pass && (state != RU_READY);

   rxs_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) walk_i (
      .clk(clk), .rst_n(rst_n), .go(go), .go_addr(base + offset), .go_len(frm_len),
      .go_status(fstat), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .link(link), .end_flag(end_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ev_frame <= 1'b0;
         ev_rnr   <= 1'b0;
         st_good  <= 1'b0;
         st_short <= 1'b0;
         st_rsrc  <= 1'b0;
      end else begin
         ev_frame <= done;
         st_good  <= done;
         ev_rnr   <= res_err | abort_rnr;
         st_rsrc  <= res_err;
         st_short <= take_f && is_short && cfg_short_cnt;
      end
   end

   assign ru_state = state;

   a_r5_rsrc_with_rnr: assert property (@(posedge clk) disable iff (!rst_n)
      st_rsrc |-> ev_rnr);
   a_r14_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_frame && ev_rnr));
   a_r7_long_drop: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && !busy && frm_len > LONG_LIM && !cfg_long_ok |=> !busy && !ev_rnr);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

endmodule

// File: tb/rx_desc_seq_tb_top.sv
module rx_desc_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_code = '0;
   logic [31:0] cmd_ptr = '0;
   logic        frm_valid = 1'b0;
   logic [15:0] frm_len = '0;
   logic [47:0] frm_dst = '0;
   logic [47:0] ind_addr = 48'h02_11_22_33_44_55;
   logic [63:0] hash_tbl = '0;
   logic        cfg_short_cnt = 1'b0, cfg_long_ok = 1'b0, cfg_promisc = 1'b0;
   logic        mem_req, mem_we, mem_rvalid = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic        busy, ev_frame, ev_rnr, st_good, st_short, st_rsrc;
   logic [3:0]  ru_state;

   always #4 clk = ~clk;

   rx_desc_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_ptr(cmd_ptr), .frm_valid(frm_valid), .frm_len(frm_len), .frm_dst(frm_dst),
      .ind_addr(ind_addr), .hash_tbl(hash_tbl), .cfg_short_cnt(cfg_short_cnt),
      .cfg_long_ok(cfg_long_ok), .cfg_promisc(cfg_promisc), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(busy),
      .ru_state(ru_state), .ev_frame(ev_frame), .ev_rnr(ev_rnr), .st_good(st_good),
      .st_short(st_short), .st_rsrc(st_rsrc)
   );

   int n_checks = 0, n_fail = 0;
   int c_frame = 0, c_rnr = 0, c_good = 0, c_short = 0, c_rsrc = 0;
   int e_frame = 0, e_rnr = 0, e_good = 0, e_short = 0, e_rsrc = 0;
   bit finished = 0;

   typedef struct packed { logic we; logic [31:0] addr; logic [31:0] data; } acc_t;
   acc_t exp_q[$];
   logic [31:0] mem [0:255];

   localparam logic [47:0] OWN   = 48'h02_11_22_33_44_55;
   localparam logic [47:0] OTHER = 48'h02_AA_BB_CC_DD_EE;
   localparam logic [47:0] MC_HIT  = 48'h01_00_5E_00_00_01;
   localparam logic [47:0] MC_MISS = 48'h01_00_5E_00_00_02;

   function automatic logic [5:0] hidx(input logic [47:0] d);
      logic [5:0] h = '0;
      for (int k = 0; k < 8; k++) h ^= d[k*6 +: 6];
      return h;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory model and scoreboard monitor
   always @(negedge clk) begin
      if (!rst_n) mem_rvalid = 1'b0;
      else if (mem_req && !mem_rvalid) begin
         if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
         else        mem_rdata = mem[mem_addr[9:2]];
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R11 actual=%0h expected=none (unexpected access)", mem_addr);
         end else begin
            acc_t e;
            e = exp_q.pop_front();
            if (e.we !== mem_we || e.addr !== mem_addr || (e.we && e.data !== mem_wdata)) begin
               n_fail++;
               $display("FAIL R11 actual=%0h/%0h/%0h expected=%0h/%0h/%0h",
                        mem_we, mem_addr, mem_wdata, e.we, e.addr, e.data);
            end
         end
         mem_rvalid = 1'b1;
      end else mem_rvalid = 1'b0;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (ev_frame) c_frame++;
         if (ev_rnr)   c_rnr++;
         if (st_good)  c_good++;
         if (st_short) c_short++;
         if (st_rsrc)  c_rsrc++;
      end
   end

   task automatic expect_store(input logic [31:0] a, input logic [15:0] cmdhi,
                               input logic [15:0] st, input logic [15:0] len);
      exp_q.push_back({1'b0, a, 32'h0});
      exp_q.push_back({1'b0, a + 32'd4, 32'h0});
      exp_q.push_back({1'b1, a, {cmdhi, st}});
      exp_q.push_back({1'b1, a + 32'd12, {16'h0, len}});
      e_frame++; e_good++;
   endtask

   task automatic set_desc(input logic [31:0] a, input logic [15:0] cmdhi, input logic [31:0] lnk);
      mem[a[9:2]]      = {cmdhi, 16'h0};
      mem[a[9:2] + 1]  = lnk;
   endtask

   task automatic do_cmd(input logic [2:0] c, input logic [31:0] p);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = c; cmd_ptr = p;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic send(input logic [15:0] len, input logic [47:0] d);
      @(negedge clk);
      frm_valid = 1'b1; frm_len = len; frm_dst = d;
      @(negedge clk);
      frm_valid = 1'b0;
   endtask

   task automatic settle();
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic chk_counts(input string req);
      chk(c_frame == e_frame, {req, " ev_frame"}, c_frame, e_frame);
      chk(c_rnr   == e_rnr,   {req, " ev_rnr"},   c_rnr,   e_rnr);
      chk(c_good  == e_good,  {req, " st_good"},  c_good,  e_good);
      chk(c_short == e_short, {req, " st_short"}, c_short, e_short);
      chk(c_rsrc  == e_rsrc,  {req, " st_rsrc"},  c_rsrc,  e_rsrc);
      chk(exp_q.size() == 0,  {req, " pending accesses"}, exp_q.size(), 0);
   endtask

   initial begin
      set_desc(32'h100, 16'h0000, 32'h20);
      set_desc(32'h120, 16'h0000, 32'h40);
      set_desc(32'h140, 16'h4000, 32'h60);
      set_desc(32'h160, 16'h0000, 32'h80);
      set_desc(32'h180, 16'h8000, 32'hA0);
      set_desc(32'h1A0, 16'h0000, 32'hC0);
      set_desc(32'h1C0, 16'h0000, 32'hE0);
      set_desc(32'h1E0, 16'h4000, 32'h100);
      set_desc(32'h200, 16'h0000, 32'h0);
      hash_tbl[hidx(MC_HIT)] = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ru_state == 4'd0, "R1 state", ru_state, 0);
      chk(!busy && !mem_req, "R1 busy/req", {busy, mem_req}, 0);
      chk_counts("R1");
      // R5 frame while idle
      send(16'd100, OWN); e_rnr++; e_rsrc++;
      settle(); chk_counts("R5 idle");
      // R4 unknown and no-op codes
      do_cmd(3'd3, 32'h0); do_cmd(3'd5, 32'h0); do_cmd(3'd7, 32'h0); do_cmd(3'd0, 32'h0);
      settle();
      chk(ru_state == 4'd0, "R4 state", ru_state, 0);
      chk_counts("R4");
      // R2 load base and start
      do_cmd(3'd6, 32'h100); do_cmd(3'd1, 32'h0);
      @(negedge clk);
      chk(ru_state == 4'd4, "R2 start", ru_state, 4);
      // R8 own address, R11 sequence
      expect_store(32'h100, 16'h0000, 16'hA000, 16'd100);
      send(16'd100, OWN); settle(); chk_counts("R8");
      chk(ru_state == 4'd4, "R12 no bits stays ready", ru_state, 4);
      // R9 multicast hit, link followed
      expect_store(32'h120, 16'h0000, 16'hA002, 16'd80);
      send(16'd80, MC_HIT); settle(); chk_counts("R9 hit");
      send(16'd90, MC_MISS); settle(); chk_counts("R9 miss");
      // R7 long frames
      send(16'd1600, OWN); settle(); chk_counts("R7 drop");
      cfg_long_ok = 1'b1;
      expect_store(32'h140, 16'h4000, 16'hA000, 16'd1600);
      send(16'd1600, OWN); settle(); chk_counts("R7 kept");
      cfg_long_ok = 1'b0;
      chk(ru_state == 4'd1, "R12 suspend bit", ru_state, 1);
      // R5 while suspended, then resume
      send(16'd100, OWN); e_rnr++; e_rsrc++; settle(); chk_counts("R5 suspended");
      do_cmd(3'd2, 32'h0); @(negedge clk);
      chk(ru_state == 4'd4, "R2 resume", ru_state, 4);
      // R10 promiscuous
      cfg_promisc = 1'b1;
      expect_store(32'h160, 16'h0000, 16'hA004, 16'd200);
      send(16'd200, OTHER); settle(); chk_counts("R10 unicast");
      expect_store(32'h180, 16'h8000, 16'hA006, 16'd90);
      send(16'd90, MC_MISS); settle(); chk_counts("R10 mcast");
      cfg_promisc = 1'b0;
      chk(ru_state == 4'd1, "R12 end of list", ru_state, 1);
      // R6 short frames
      cfg_short_cnt = 1'b1;
      send(16'd40, OWN); e_short++; e_rnr++; e_rsrc++; settle(); chk_counts("R6 not ready");
      do_cmd(3'd2, 32'h0);
      expect_store(32'h1A0, 16'h0000, 16'hA000, 16'd40);
      send(16'd40, OWN); e_short++; settle(); chk_counts("R6 stored");
      cfg_short_cnt = 1'b0;
      // R13 ignore while busy
      expect_store(32'h1C0, 16'h0000, 16'hA000, 16'd64);
      send(16'd64, OWN);
      chk(busy == 1'b1, "R13 busy", busy, 1);
      do_cmd(3'd4, 32'h0);
      send(16'd64, OWN);
      chk(ru_state == 4'd4, "R13 abort ignored", ru_state, 4);
      settle(); chk_counts("R13");
      chk(ru_state == 4'd4, "R13 state after", ru_state, 4);
      // R3 abort
      do_cmd(3'd4, 32'h0); e_rnr++; settle();
      chk(ru_state == 4'd0, "R3 abort", ru_state, 0); chk_counts("R3 ready");
      do_cmd(3'd4, 32'h0); settle(); chk_counts("R3 idle");
      // R14 frame and abort in the same cycle
      do_cmd(3'd1, 32'hE0);
      expect_store(32'h1E0, 16'h4000, 16'hA000, 16'd70); e_rnr++;
      @(negedge clk);
      frm_valid = 1'b1; frm_len = 16'd70; frm_dst = OWN;
      cmd_valid = 1'b1; cmd_code = 3'd4;
      @(negedge clk);
      frm_valid = 1'b0; cmd_valid = 1'b0;
      chk(ru_state == 4'd0, "R14 idle during", ru_state, 0);
      settle(); chk_counts("R14");
      chk(ru_state == 4'd0, "R14 no suspend", ru_state, 0);
      do_cmd(3'd2, 32'h0);
      expect_store(32'h200, 16'h0000, 16'hA000, 16'd66);
      send(16'd66, OWN); settle(); chk_counts("R14 link");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule